// File: doc/BRIEF.md
# CMI Line Coder and Decoder with Test Loopback

This block converts a serial binary stream into a two-level Code Mark Inversion line signal, and converts a received CMI line signal back into binary data. The transmit and receive halves each have their own clock, running at twice the line bit rate. The coder halves its clock to produce a bit clock for the upstream data source. The decoder finds the half-bit phase of the incoming line signal by itself. Until it has that phase, it keeps its data and bit-clock outputs quiet. Once locked, it flags code violations.

Two test controls reroute traffic without touching the coding logic. The binary-side control returns the coder's input data and bit clock straight to the decoder's binary outputs. The line-side control returns the received line signal straight to the line output. The two controls act independently and can be combined. The line runs at a fixed rate and cannot be stalled, so there is no valid/ready handshake and no back-pressure. Every data pin carries one value per half-bit or per bit, as described below.

Top module: `cmi_codec`

## Requirements
- R1: `tx_bclk` toggles on every rising edge of `clk_tx` and is low after reset. The coder samples `tx_bin` on each `clk_tx` edge at which `tx_bclk` is low, so `tx_bclk` is high while the first half of that bit is on the line.
- R2: A sampled 0 is sent as `cmi_out` low for the first half-bit and high for the second. The first half appears after the sampling edge and the second half one `clk_tx` cycle later.
- R3: A sampled 1 is sent with both halves at the same level. That level alternates on each successive 1, and the first 1 after reset is sent high.
- R4: Driving `rst_n` low immediately, without a clock edge, sets `cmi_out`, `tx_bclk`, `rx_bin`, `rx_bclk` and `viol` low, provided both loopbacks are off. After reset, the mark polarity restarts at high and the decoder must relock.
- R5: While hunting, the decoder examines one half-bit pair every second `clk_rx` cycle. After SLIP_N high-then-low pairs since the last slip, it delays its pairing by one `clk_rx` cycle. It locks after LOCK_N consecutive examined pairs that are not high-then-low, and it stays locked until reset.
- R6: Once locked, the decoder issues one `rx_bclk` pulse, one `clk_rx` cycle wide, per received bit. `rx_bin` holds the decoded bit from that pulse until the next one: 0 for a low-then-high pair and 1 for a pair of equal halves.
- R7: With a decoded bit, `viol` is high for a high-then-low pair, which decodes as 0. It is also high for a 1 whose level equals that of the previous 1 received since lock. The first 1 after lock is never flagged.
- R8: Before lock, `rx_bclk`, `rx_bin` and `viol` stay low, whatever arrives on `cmi_in`.
- R9: With `lb_bin` high, `rx_bin` follows `tx_bin`, `rx_bclk` follows `tx_bclk` and `viol` is low, combinationally.
- R10: With `lb_line` high, `cmi_out` follows `cmi_in` combinationally.
- R11: With both loopback controls high, the R9 and R10 paths act together, each unaffected by the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Coder clock at twice the bit rate |
| clk_rx | input | 1 | Decoder clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset for both halves |
| tx_bin | input | 1 | Binary data to encode |
| tx_bclk | output | 1 | Bit-rate clock for the data source |
| cmi_out | output | 1 | Encoded line signal |
| cmi_in | input | 1 | Received line signal |
| rx_bin | output | 1 | Decoded binary data |
| rx_bclk | output | 1 | Recovered bit strobe |
| lb_bin | input | 1 | Binary-side loopback select |
| lb_line | input | 1 | Line-side loopback select |
| viol | output | 1 | Code violation flag, aligned with the decoded bit |

## Verification
A wrong mark-polarity register shows at the next 1: both halves of that bit go out at the wrong level. A wrong coder phase shows within one half-bit as swapped 0 halves and a wrong `tx_bclk` level. In the decoder, a lost or wrong pairing phase shows as the decoded payload failing to match the expected bits. A pairing that never settles shows as `rx_bclk` never pulsing. A stale polarity memory shows as `viol` raised on a legal 1, or missing on a repeated one, at that very bit.

// File: rtl/cmi_pkg.sv
package cmi_pkg;

  // Two consecutive half-bit samples, earlier sample in the upper bit
  typedef enum logic [1:0] {
    PAIR_LL = 2'b00,
    PAIR_LH = 2'b01,
    PAIR_HL = 2'b10,
    PAIR_HH = 2'b11
  } pair_e;

  localparam int unsigned DEF_LOCK_N = 8;
  localparam int unsigned DEF_SLIP_N = 2;

endpackage

// File: rtl/cmi_coder.sv
module cmi_coder (
  input  logic clk,
  input  logic rst_n,
  input  logic bin_i,
  output logic bclk_o,
  output logic cmi_o
);

  logic ph_q;    // 0: next edge starts a bit, 1: next edge starts second half
  logic bit_q;   // bit currently on the line
  logic mark_q;  // level for the next 1
  logic cmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      bit_q  <= 1'b0;
      mark_q <= 1'b1;
      cmi_q  <= 1'b0;
    end else begin
      ph_q <= ~ph_q;
      if (!ph_q) begin
        bit_q <= bin_i;
        cmi_q <= bin_i ? mark_q : 1'b0;
      end else begin
        cmi_q <= bit_q ? mark_q : 1'b1;
        if (bit_q) mark_q <= ~mark_q;
      end
    end
  end

  assign bclk_o = ph_q;
  assign cmi_o  = cmi_q;

  // R2: the second half of a 0 rises from the low first half
  a_r2_zero_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q && !bit_q) |=> (cmi_q && !$past(cmi_q)));

  // R3: both halves of a 1 carry the same level
  a_r3_one_flat: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q && bit_q) |=> (cmi_q == $past(cmi_q)));

endmodule

// File: rtl/cmi_decoder.sv
module cmi_decoder
  import cmi_pkg::*;
#(
  parameter int unsigned LOCK_N = DEF_LOCK_N,
  parameter int unsigned SLIP_N = DEF_SLIP_N
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmi_i,
  output logic bin_o,
  output logic bclk_o,
  output logic viol_o
);

  localparam int unsigned LW = $clog2(LOCK_N + 1);
  localparam int unsigned SW = $clog2(SLIP_N + 1);

  logic          h0_q, h1_q;       // newest and previous half-bit samples
  logic          rph_q;            // high: examine the pair on this edge
  logic          locked_q;
  logic [LW-1:0] good_q;
  logic [SW-1:0] bad_q;
  logic          mark_known_q, mark_q;
  logic          bin_q, bclk_q, viol_q;
  pair_e         pair;
  logic          slip;

  assign pair = pair_e'({h1_q, h0_q});
  assign slip = rph_q && !locked_q && (pair == PAIR_HL) && (bad_q == SW'(SLIP_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0_q         <= 1'b0;
      h1_q         <= 1'b0;
      rph_q        <= 1'b0;
      locked_q     <= 1'b0;
      good_q       <= '0;
      bad_q        <= '0;
      mark_known_q <= 1'b0;
      mark_q       <= 1'b0;
      bin_q        <= 1'b0;
      bclk_q       <= 1'b0;
      viol_q       <= 1'b0;
    end else begin
      h0_q   <= cmi_i;
      h1_q   <= h0_q;
      rph_q  <= slip ? rph_q : ~rph_q;
      bclk_q <= 1'b0;
      if (rph_q) begin
        if (!locked_q) begin
          if (pair == PAIR_HL) begin
            good_q <= '0;
            bad_q  <= slip ? '0 : bad_q + SW'(1);
          end else begin
            good_q <= good_q + LW'(1);
            if (good_q == LW'(LOCK_N - 1)) locked_q <= 1'b1;
          end
        end else begin
          bclk_q <= 1'b1;
          bin_q  <= (h1_q == h0_q);
          viol_q <= 1'b0;
          case (pair)
            PAIR_HL: viol_q <= 1'b1;
            PAIR_LL, PAIR_HH: begin
              if (mark_known_q && (mark_q == h1_q)) viol_q <= 1'b1;
              mark_q       <= h1_q;
              mark_known_q <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign bin_o  = bin_q;
  assign bclk_o = bclk_q;
  assign viol_o = viol_q;

  // R8: outputs stay quiet while hunting
  a_r8_quiet_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> (!bclk_q && !bin_q && !viol_q));

  // R6: the bit strobe is a single-cycle pulse
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_q |=> !bclk_q);

  // R7: a new violation arrives only together with a decoded bit
  a_r7_viol_with_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_q) |-> bclk_q);

  // R5: lock is kept until reset
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);

endmodule

// File: rtl/cmi_loopback.sv
module cmi_loopback (
  input  logic lb_bin_i,
  input  logic lb_line_i,
  input  logic src_bin_i,
  input  logic src_bclk_i,
  input  logic dec_bin_i,
  input  logic dec_bclk_i,
  input  logic dec_viol_i,
  input  logic enc_cmi_i,
  input  logic line_cmi_i,
  output logic rx_bin_o,
  output logic rx_bclk_o,
  output logic viol_o,
  output logic cmi_o
);

  always_comb begin
    rx_bin_o  = lb_bin_i ? src_bin_i  : dec_bin_i;
    rx_bclk_o = lb_bin_i ? src_bclk_i : dec_bclk_i;
    viol_o    = lb_bin_i ? 1'b0       : dec_viol_i;
    cmi_o     = lb_line_i ? line_cmi_i : enc_cmi_i;
  end

endmodule

// File: rtl/cmi_codec.sv
module cmi_codec
  import cmi_pkg::*;
#(
  parameter int unsigned LOCK_N = DEF_LOCK_N,
  parameter int unsigned SLIP_N = DEF_SLIP_N
) (
  input  logic clk_tx,
  input  logic clk_rx,
  input  logic rst_n,
  input  logic tx_bin,
  output logic tx_bclk,
  output logic cmi_out,
  input  logic cmi_in,
  output logic rx_bin,
  output logic rx_bclk,
  input  logic lb_bin,
  input  logic lb_line,
  output logic viol
);

  logic enc_cmi;
  logic dec_bin, dec_bclk, dec_viol;

  cmi_coder u_coder (
    .clk    (clk_tx),
    .rst_n  (rst_n),
    .bin_i  (tx_bin),
    .bclk_o (tx_bclk),
    .cmi_o  (enc_cmi)
  );

  cmi_decoder #(
    .LOCK_N (LOCK_N),
    .SLIP_N (SLIP_N)
  ) u_decoder (
    .clk    (clk_rx),
    .rst_n  (rst_n),
    .cmi_i  (cmi_in),
    .bin_o  (dec_bin),
    .bclk_o (dec_bclk),
    .viol_o (dec_viol)
  );

  cmi_loopback u_loop (
    .lb_bin_i   (lb_bin),
    .lb_line_i  (lb_line),
    .src_bin_i  (tx_bin),
    .src_bclk_i (tx_bclk),
    .dec_bin_i  (dec_bin),
    .dec_bclk_i (dec_bclk),
    .dec_viol_i (dec_viol),
    .enc_cmi_i  (enc_cmi),
    .line_cmi_i (cmi_in),
    .rx_bin_o   (rx_bin),
    .rx_bclk_o  (rx_bclk),
    .viol_o     (viol),
    .cmi_o      (cmi_out)
  );

endmodule

// File: tb/test_cmi_codec.sv
module test_cmi_codec;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_bin = 1'b0, cmi_in = 1'b0, lb_bin = 1'b0, lb_line = 1'b0;
  logic tx_bclk, cmi_out, rx_bin, rx_bclk, viol;

  int n_chk = 0;
  int n_bad = 0;
  logic bm;

  logic rec_bin  [1024];
  logic rec_viol [1024];
  int   rec_n = 0;

  always #5 clk = ~clk;

  cmi_codec i_cmi_codec (
    .clk_tx (clk), .clk_rx (clk), .rst_n (rst_n),
    .tx_bin (tx_bin), .tx_bclk (tx_bclk), .cmi_out (cmi_out),
    .cmi_in (cmi_in), .rx_bin (rx_bin), .rx_bclk (rx_bclk),
    .lb_bin (lb_bin), .lb_line (lb_line), .viol (viol)
  );

  // record every decoded bit strobe
  always @(negedge clk) begin
    if (rst_n && !lb_bin && rx_bclk && rec_n < 1024) begin
      rec_bin[rec_n]  = rx_bin;
      rec_viol[rec_n] = viol;
      rec_n = rec_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmi_in = 1'b0;
    tx_bin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_half(input logic v);
    cmi_in = v;
    @(negedge clk);
  endtask

  task automatic enc_bit(input logic b, input bit keep);
    if (!b) begin
      send_half(1'b0);
      send_half(1'b1);
    end else begin
      send_half(bm);
      send_half(bm);
      if (!keep) bm = ~bm;
    end
  endtask

  task automatic coder_bit(input logic b, output logic f, output logic s,
                           output logic c1, output logic c2);
    while (tx_bclk) @(negedge clk);
    tx_bin = b;
    @(negedge clk);
    f = cmi_out; c1 = tx_bclk;
    @(negedge clk);
    s = cmi_out; c2 = tx_bclk;
  endtask

  // locate the first decoded 1 from base and compare n bits against expectations
  task automatic compare_run(input int base, input logic [15:0] eb, input logic [15:0] ev,
                             input int n, input string tag);
    int first = -1;
    bit pre_ok = 1'b1;
    for (int i = base; i < rec_n; i++) begin
      if (first < 0 && rec_bin[i]) first = i;
    end
    check(first >= 0 && first + n <= rec_n, {tag, " R5 lock and payload seen"}, first, base);
    if (first >= 0 && first + n <= rec_n) begin
      for (int i = base; i < first; i++) if (rec_viol[i]) pre_ok = 1'b0;
      check(pre_ok, {tag, " R6 preamble decodes as clean 0s"}, 0, 0);
      for (int i = 0; i < n; i++) begin
        check(rec_bin[first+i] == eb[i], {tag, " R6 decoded bit"}, int'(rec_bin[first+i]), int'(eb[i]));
        check(rec_viol[first+i] == ev[i], {tag, " R7 violation flag"}, int'(rec_viol[first+i]), int'(ev[i]));
      end
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(!cmi_out && !tx_bclk, "R4 coder quiet in reset", int'({cmi_out, tx_bclk}), 0);
    check(!rx_bin && !rx_bclk && !viol, "R4 decoder quiet in reset", int'({rx_bin, rx_bclk, viol}), 0);
  endtask

  task automatic t_coder();
    logic [9:0] bits = 10'b1110010110;
    logic f, s, c1, c2, m;
    do_reset();
    m = 1'b1;
    for (int i = 0; i < 10; i++) begin
      coder_bit(bits[i], f, s, c1, c2);
      check(c1 && !c2, "R1 tx_bclk high in first half, low in second", int'({c1, c2}), 2);
      if (!bits[i]) begin
        check({f, s} == 2'b01, "R2 zero halves", int'({f, s}), 1);
      end else begin
        check(f == m && s == m, "R3 one halves follow alternating mark", int'({f, s}), int'({m, m}));
        m = ~m;
      end
    end
  endtask

  task automatic t_async_reset();
    logic f, s, c1, c2;
    do_reset();
    coder_bit(1'b1, f, s, c1, c2);   // sent high, next 1 goes low
    while (tx_bclk) @(negedge clk);
    tx_bin = 1'b1;
    @(negedge clk);
    check(cmi_out == 1'b0 && tx_bclk, "R3 second 1 starts low", int'({cmi_out, tx_bclk}), 1);
    #2 rst_n = 1'b0;
    #1;
    check(!cmi_out && !tx_bclk, "R4 asynchronous clear of coder", int'({cmi_out, tx_bclk}), 0);
    check(!rx_bin && !rx_bclk && !viol, "R4 asynchronous clear of decoder", int'({rx_bin, rx_bclk, viol}), 0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    coder_bit(1'b1, f, s, c1, c2);
    check(f && s, "R4 mark polarity restarts high", int'({f, s}), 3);
  endtask

  task automatic t_quiet();
    bit ok = 1'b1;
    do_reset();
    for (int i = 0; i < 12; i++) begin
      send_half(i[0] ? 1'b0 : 1'b1);   // misaligned zero stream
      if (rx_bclk || rx_bin || viol) ok = 1'b0;
    end
    check(ok, "R8 outputs quiet before lock", int'({rx_bclk, rx_bin, viol}), 0);
  endtask

  task automatic t_decode_aligned();
    int base;
    do_reset();
    base = rec_n;
    bm = 1'b1;
    send_half(1'b0);                       // matches the decoder's initial pairing
    for (int i = 0; i < 16; i++) enc_bit(1'b0, 1'b0);
    enc_bit(1'b1, 1'b0); enc_bit(1'b0, 1'b0); enc_bit(1'b1, 1'b0); enc_bit(1'b1, 1'b0);
    enc_bit(1'b0, 1'b0); enc_bit(1'b0, 1'b0); enc_bit(1'b1, 1'b0); enc_bit(1'b0, 1'b0);
    enc_bit(1'b1, 1'b0); enc_bit(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) enc_bit(1'b0, 1'b0);
    compare_run(base, 16'b0000_0011_0100_1101, 16'h0000, 10, "aligned");
  endtask

  task automatic t_decode_slip();
    int base;
    do_reset();
    base = rec_n;
    bm = 1'b1;
    for (int i = 0; i < 20; i++) enc_bit(1'b0, 1'b0);   // starts half a bit off
    enc_bit(1'b1, 1'b1);          // high, polarity kept for the next 1
    enc_bit(1'b1, 1'b0);          // high again: repeated polarity
    enc_bit(1'b0, 1'b0);
    send_half(1'b1); send_half(1'b0);   // forbidden high-then-low pair
    enc_bit(1'b0, 1'b0);
    enc_bit(1'b1, 1'b0);          // low
    enc_bit(1'b0, 1'b0);
    enc_bit(1'b1, 1'b0);          // high
    for (int i = 0; i < 4; i++) enc_bit(1'b0, 1'b0);
    // bits in order: 1 1 0 0 0 1 0 1 ; violations on the 2nd and 4th
    compare_run(base, 16'b0000_0000_1010_0011, 16'b0000_0000_0000_1010, 8, "slipped");
  endtask

  task automatic t_lb_bin();
    do_reset();
    lb_bin = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #1 tx_bin = i[1]; cmi_in = ~i[0];
      #1;
      check(rx_bin == tx_bin, "R9 binary loopback data", int'(rx_bin), int'(tx_bin));
      check(rx_bclk == tx_bclk && !viol, "R9 binary loopback clock and flag",
            int'({rx_bclk, viol}), int'({tx_bclk, 1'b0}));
    end
    lb_bin = 1'b0;
  endtask

  task automatic t_lb_line();
    do_reset();
    lb_line = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      #1 cmi_in = i[0] ^ i[2];
      #1;
      check(cmi_out == cmi_in, "R10 line loopback", int'(cmi_out), int'(cmi_in));
    end
    lb_line = 1'b0;
  endtask

  task automatic t_lb_both();
    do_reset();
    lb_bin = 1'b1;
    lb_line = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1 tx_bin = i[0]; cmi_in = ~i[1];
      #1;
      check(cmi_out == cmi_in && rx_bin == tx_bin, "R11 both loopbacks together",
            int'({cmi_out, rx_bin}), int'({cmi_in, tx_bin}));
    end
    lb_bin = 1'b0;
    lb_line = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_coder();
    t_async_reset();
    t_quiet();
    t_decode_aligned();
    t_decode_slip();
    t_lb_bin();
    t_lb_line();
    t_lb_both();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule